// File: doc/BRIEF.md
# Receive-Line Baud Auto-Tune

This block sizes the bit time of a training character that a remote sender puts on the receive line. The character alternates between 1 and 0 on every bit, so the line falls once every two bit periods. Software arms the block with a one-cycle pulse. The first falling edge after arming marks the start bit and starts a tick counter. Each following falling edge closes a span of two bits. At that edge the block publishes half the span's tick count as the per-bit interval and raises a sticky done flag.

The tick counter advances only on cycles where the measurement clock enable is high, so the caller picks the time base. The fourth falling edge closes the span over the last pair of bits measured. At that edge the block offers that span's per-bit value as a revised divisor, with a one-cycle write strobe, and then disarms itself. If a span holds more ticks than the counter can represent, the block raises an error together with the done flag, saturates the interval, skips the divisor write and disarms. Sticky flags and the interval are cleared by write-one pulses.

Top module: `abr_detect`

## Requirements
- R1: After reset, enable_o, done_o, err_o and div_we_o are 0 and itv_o is 0.
- R2: An arm_i pulse sets enable_o in the next cycle and restarts detection. Falling edges of rx_i while enable_o is 0 leave itv_o, done_o and err_o unchanged.
- R3: The first falling edge after arming starts timing and sets neither done_o nor itv_o.
- R4: At each of the 2nd, 3rd and 4th falling edges, itv_o becomes floor(T/2) and done_o becomes 1 at the clock edge that samples the fall. T is the number of cycles with tick_i high, from the cycle after the previous falling edge up to and including the cycle of this one.
- R5: Cycles with tick_i low add nothing to T.
- R6: At the 4th falling edge without overrun, div_we_o is 1 for exactly one cycle, with div_o equal to that span's itv value zero-extended. In every other cycle div_o equals div_i.
- R7: enable_o clears at the 4th falling edge. Later falling edges change nothing until the next arm_i.
- R8: If T exceeds 2^(ITV_W+1)-1 (1023 by default), then at that edge done_o and err_o both become 1, itv_o becomes all ones, enable_o clears and div_we_o stays 0.
- R9: clr_done_i clears done_o and err_o. clr_err_i clears only err_o. A hardware set in the same cycle wins over a clear.
- R10: clr_itv_i sets itv_o to 0 unless a span closes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronized receive line |
| tick_i | input | 1 | Measurement clock enable |
| arm_i | input | 1 | Start detection (pulse) |
| clr_done_i | input | 1 | Write-one clear of done and error |
| clr_err_i | input | 1 | Write-one clear of error |
| clr_itv_i | input | 1 | Write-one clear of interval |
| div_i | input | DIV_W | Current divisor |
| enable_o | output | 1 | Detection armed |
| done_o | output | 1 | Sticky span-measured flag |
| err_o | output | 1 | Sticky counter-overrun flag |
| itv_o | output | ITV_W | Per-bit interval in ticks |
| div_o | output | DIV_W | Divisor value (revised during strobe) |
| div_we_o | output | 1 | Divisor write strobe |

## Verification
Training characters are sent with a bit length of 8 cycles while tick_i is always high. This shows that the interval is half the span and that the divisor strobe lands on the fourth fall. A 12-cycle bit with tick_i toggling every cycle separates tick counting from cycle counting. A 600-cycle bit drives the counter past its range and shows that the error path suppresses the divisor write. Frames sent before arming and after completion, a start bit cut short by a re-arm, and each clear pulse show what the block must ignore.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_TIME} abr_state_e;
endpackage

// File: rtl/abr_edge.sv
module abr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/abr_timer.sv
module abr_timer #(
  parameter int CNT_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic           tick_i,
  output logic [CNT_W:0] meas_o,
  output logic           ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_MAX) & tick_i;
  assign meas_o = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick_i};
  assign ovf_o  = ovf_q | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (run_i) begin
      if (wrap) ovf_q <= 1'b1;
      else      cnt_q <= meas_o[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/abr_ctrl.sv
module abr_ctrl
  import abr_pkg::*;
#(
  parameter int ITV_W  = 9,
  parameter int DIV_W  = 10,
  parameter int N_FALL = 4,
  localparam int CNT_W = ITV_W + 1,
  localparam int N_W   = $clog2(N_FALL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             fall_i,
  input  logic [CNT_W:0]   meas_i,
  input  logic             ovf_i,
  input  logic             clr_done_i,
  input  logic             clr_err_i,
  input  logic             clr_itv_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             run_o,
  output logic             restart_o,
  output logic             enable_o,
  output logic             done_o,
  output logic             err_o,
  output logic [ITV_W-1:0] itv_o,
  output logic [DIV_W-1:0] div_o,
  output logic             div_we_o
);
  localparam logic [N_W-1:0] LAST_SPAN = N_W'(N_FALL - 2);

  abr_state_e       state_q;
  logic [N_W-1:0]   span_q;
  logic [ITV_W-1:0] rev_q;
  logic             we_q;
  logic             span_evt;
  logic [ITV_W-1:0] half;

  assign half      = meas_i[ITV_W:1];
  assign span_evt  = (state_q == ST_TIME) & fall_i & ~arm_i;
  assign run_o     = (state_q == ST_TIME);
  assign restart_o = arm_i | (fall_i & (state_q != ST_IDLE));
  assign enable_o  = (state_q != ST_IDLE);
  assign div_we_o  = we_q;
  assign div_o     = we_q ? DIV_W'(rev_q) : div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      span_q  <= '0;
      rev_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (arm_i) begin
        state_q <= ST_WAIT;
        span_q  <= '0;
      end else begin
        unique case (state_q)
          ST_WAIT: if (fall_i) state_q <= ST_TIME;
          ST_TIME: if (fall_i) begin
            if (ovf_i) state_q <= ST_IDLE;
            else if (span_q == LAST_SPAN) begin
              state_q <= ST_IDLE;
              we_q    <= 1'b1;
              rev_q   <= half;
            end else span_q <= span_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      itv_o  <= '0;
    end else begin
      if (span_evt)        done_o <= 1'b1;
      else if (clr_done_i) done_o <= 1'b0;

      if (span_evt & ovf_i)             err_o <= 1'b1;
      else if (clr_done_i | clr_err_i)  err_o <= 1'b0;

      if (span_evt)       itv_o <= ovf_i ? '1 : half;
      else if (clr_itv_i) itv_o <= '0;
    end
  end
endmodule

// File: rtl/abr_detect.sv
module abr_detect #(
  parameter int ITV_W  = 9,
  parameter int DIV_W  = 10,
  parameter int N_FALL = 4,
  localparam int CNT_W = ITV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             clr_done_i,
  input  logic             clr_err_i,
  input  logic             clr_itv_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             enable_o,
  output logic             done_o,
  output logic             err_o,
  output logic [ITV_W-1:0] itv_o,
  output logic [DIV_W-1:0] div_o,
  output logic             div_we_o
);
  logic           fall, run, restart, ovf;
  logic [CNT_W:0] meas;

  abr_edge i_edge (.clk_i, .rst_ni, .rx_i, .fall_o(fall));

  abr_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .run_i(run), .restart_i(restart), .tick_i,
    .meas_o(meas), .ovf_o(ovf)
  );

  abr_ctrl #(.ITV_W(ITV_W), .DIV_W(DIV_W), .N_FALL(N_FALL)) i_ctrl (
    .clk_i, .rst_ni, .arm_i, .fall_i(fall), .meas_i(meas), .ovf_i(ovf),
    .clr_done_i, .clr_err_i, .clr_itv_i, .div_i,
    .run_o(run), .restart_o(restart), .enable_o, .done_o, .err_o,
    .itv_o, .div_o, .div_we_o
  );
endmodule

// File: rtl/abr_detect_chk.sv
module abr_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_o,
  input logic done_o,
  input logic err_o,
  input logic div_we_o
);
  assert_we_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_o |=> !div_we_o);
  assert_we_disarms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_o |-> !enable_o);
  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  assert_err_no_we_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !div_we_o && !enable_o);
  assert_done_armed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(enable_o));
endmodule

bind abr_detect abr_detect_chk i_abr_detect_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_o(enable_o), .done_o(done_o),
  .err_o(err_o), .div_we_o(div_we_o)
);

// File: tb/test_abr_detect.sv
module test_abr_detect;
  localparam int ITV_W = 9;
  localparam int DIV_W = 10;
  localparam int LIMIT = 1023;

  logic clk = 0, rst_n = 0;
  logic rx = 1, tick = 1, arm = 0, clr_done = 0, clr_err = 0, clr_itv = 0;
  logic [DIV_W-1:0] div_in = 10'h155;
  logic enable, done, err, div_we;
  logic [ITV_W-1:0] itv;
  logic [DIV_W-1:0] div_out;
  int total = 0, bad = 0, cycles = 0, we_cnt = 0, last_div = -1;
  bit tick_alt = 0;

  // reference model state
  int m_en = 0, m_edges = 0, m_cnt = 0, m_itv = 0, m_done = 0, m_err = 0;
  int m_we = 0, m_rev = 0, m_prev = 1;

  always #2 clk = ~clk;

  abr_detect i_abr_detect (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .arm_i(arm),
    .clr_done_i(clr_done), .clr_err_i(clr_err), .clr_itv_i(clr_itv),
    .div_i(div_in), .enable_o(enable), .done_o(done), .err_o(err),
    .itv_o(itv), .div_o(div_out), .div_we_o(div_we)
  );

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int fall, meas, ovf, evt;
    if (!rst_n) begin
      m_en = 0; m_edges = 0; m_cnt = 0; m_itv = 0; m_done = 0; m_err = 0;
      m_we = 0; m_prev = 1;
    end else begin
      fall = (m_prev == 1 && rx == 0);
      meas = m_cnt + tick;
      ovf  = meas > LIMIT;
      evt  = 0;
      m_we = 0;
      if (arm) begin
        m_en = 1; m_edges = 0; m_cnt = 0;
      end else if (m_en && fall) begin
        if (m_edges == 0) m_edges = 1;
        else begin
          evt = 1;
          if (ovf) m_en = 0;
          else if (m_edges == 3) begin m_en = 0; m_we = 1; m_rev = meas / 2; end
          else m_edges++;
        end
        m_cnt = 0;
      end else if (m_en && m_edges > 0) m_cnt = meas;
      if (evt) m_done = 1; else if (clr_done) m_done = 0;
      if (evt && ovf) m_err = 1; else if (clr_done || clr_err) m_err = 0;
      if (evt) m_itv = ovf ? 511 : meas / 2; else if (clr_itv) m_itv = 0;
      m_prev = rx;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R7 enable", enable, m_en);
      chk("R4 done", done, m_done);
      chk("R8 err", err, m_err);
      chk("R4 itv", itv, m_itv);
      chk("R6 div_we", div_we, m_we);
      chk("R6 div", div_out, m_we ? m_rev : div_in);
      if (div_we) begin we_cnt++; last_div = div_out; end
    end
  end

  always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic send55(int b);
    @(negedge clk); rx = 0; wait_n(b);
    for (int i = 0; i < 8; i++) begin
      rx = (8'h55 >> i) & 1; wait_n(b);
    end
    rx = 1; wait_n(b + 4);
  endtask

  initial begin
    int we_before;
    wait_n(3);
    chk("R1 enable", enable, 0);
    chk("R1 done", done, 0);
    chk("R1 itv", itv, 0);
    chk("R1 div_we", div_we, 0);
    @(negedge clk); rst_n = 1;
    wait_n(2);
    chk("R1 err", err, 0);

    send55(8);  // not armed
    chk("R2 itv unarmed", itv, 0);
    chk("R2 done unarmed", done, 0);

    pulse(arm);
    wait_n(1);
    chk("R2 enable", enable, 1);
    rx = 0; wait_n(3); rx = 1; wait_n(3);
    chk("R3 done after start", done, 0);
    chk("R3 itv after start", itv, 0);
    pulse(arm);  // restart

    send55(8);
    chk("R4 itv b8", itv, 8);
    chk("R4 done b8", done, 1);
    chk("R6 div b8", last_div, 8);
    chk("R6 we count", we_cnt, 1);
    chk("R7 disarmed", enable, 0);
    chk("R6 div passthru", div_out, div_in);

    pulse(clr_itv);
    wait_n(1);
    chk("R10 itv cleared", itv, 0);
    we_before = we_cnt;
    send55(5);  // after completion
    chk("R7 ignored itv", itv, 0);
    chk("R7 ignored we", we_cnt, we_before);

    pulse(clr_done);
    wait_n(1);
    chk("R9 done cleared", done, 0);

    tick_alt = 1;
    pulse(arm);
    send55(12);
    chk("R5 itv gated", itv, 6);
    chk("R5 div gated", last_div, 6);
    tick_alt = 0;

    we_before = we_cnt;
    pulse(arm);
    send55(600);
    chk("R8 err", err, 1);
    chk("R8 done", done, 1);
    chk("R8 itv sat", itv, 511);
    chk("R8 disarmed", enable, 0);
    chk("R8 no div write", we_cnt, we_before);

    pulse(clr_err);
    wait_n(1);
    chk("R9 err cleared", err, 0);
    chk("R9 done kept", done, 1);

    wait_n(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule